// File: doc/BRIEF.md
# Card Slot Power Mode Controller

This block decides, for a single removable-card slot, which of three rail switches (auxiliary, 3.3 V and 1.5 V) are closed and which output discharge pulldowns are active. It watches flags saying whether each input supply is present, two active-low card-detect lines, an active-low shutdown request and an active-low standby request. From these it chooses one of five power modes and drives per-rail switch and pulldown enables. The chosen mode also appears as a 3-bit code.

The choice cannot be made from the inputs alone. A standby request means "power nothing" if it arrives before a card, but "keep only auxiliary power" once a card is already running. Releasing shutdown must bring back whatever mode was active before it. The controller therefore keeps the pre-shutdown mode in a history register. It also sequences every rail so that a switch and its pulldown are never on together. A dead cycle, in which both are off, separates them in either direction.

Rail vectors use bit 0 for auxiliary, bit 1 for 3.3 V and bit 2 for 1.5 V.

Top module: `slot_power_ctrl`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, the mode code is 0 (OFF) and both rail vectors are 3'b000.
- R2: Whenever the auxiliary supply flag is low, the mode code becomes 0 (OFF) at the next clock edge, and both rail vectors settle to 3'b000.
- R3: With auxiliary present and shutdown low, the mode code becomes 1 (Shutdown) at the next edge, and the outputs settle to switches 3'b000 and pulldowns 3'b111.
- R4: When shutdown is released, the mode and rail outputs return to those held before shutdown was asserted. A slot in Standby returns to Standby, and a slot in Card Inserted returns to Card Inserted.
- R5: With all three supplies present and both card-detect lines high (no card), the mode code becomes 2 (No Card), with switches 3'b000 and pulldowns 3'b111.
- R6: A card counts as present when either card-detect line is low. From OFF or No Card, with all supplies present and standby high, the mode code becomes 4 (Card Inserted), with switches 3'b111 and pulldowns 3'b000.
- R7: In Card Inserted, a low standby request or the loss of the 3.3 V or 1.5 V supply gives mode code 3 (Standby): switches 3'b001 and pulldowns 3'b000. With standby high and all supplies present again, the mode returns to 4.
- R8: If standby is low, or the 3.3 V or 1.5 V supply is missing, when a card appears, the mode is 0 (OFF) with nothing powered. When the missing condition later clears with the card still present, the mode becomes 4.
- R9: No rail ever has its switch and pulldown enabled together. A switch turns on only if its pulldown was off on the previous cycle, and a pulldown turns on only if its switch was off on the previous cycle.
- R10: The mode code changes on the first clock edge after its inputs change. A rail switch follows one edge after the mode when its pulldown is already off, and two edges after the mode when the pulldown must first be cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| aux_ok | input | 1 | Auxiliary input supply present |
| v33_ok | input | 1 | 3.3 V input supply present |
| v15_ok | input | 1 | 1.5 V input supply present |
| det_pcie_n | input | 1 | Card-detect line, active low |
| det_usb_n | input | 1 | Second card-detect line, active low |
| shdn_req_n | input | 1 | Shutdown request, active low |
| stby_req_n | input | 1 | Standby request, active low |
| rail_sw_en | output | 3 | Switch enables, bit0 AUX, bit1 3.3 V, bit2 1.5 V |
| rail_dis_en | output | 3 | Discharge pulldown enables, same bit order |
| mode_code | output | 3 | 0 OFF, 1 Shutdown, 2 No Card, 3 Standby, 4 Card Inserted |

## Verification
A corrupted history register is exposed on shutdown release: the mode code comes back as something other than the pre-shutdown code on the first edge after release. The switch pattern follows that wrong code one or two edges later. A mode register that decodes its inputs without history shows up on the standby-before-card path, where it would report 3 instead of 0. A broken per-rail sequencer shows up on a transition in which a pulldown must give way to a switch: the dead cycle goes missing, or the overlap appears, on the second edge after the mode changes.

// File: rtl/spc_pkg.sv
package spc_pkg;
  localparam int RAILS    = 3;
  localparam int MODE_W   = 3;
  localparam int R_AUX    = 0;
  localparam int R_V33    = 1;
  localparam int R_V15    = 2;

  typedef enum logic [MODE_W-1:0] {
    M_OFF    = 3'd0,
    M_SHDN   = 3'd1,
    M_NOCARD = 3'd2,
    M_STBY   = 3'd3,
    M_CARD   = 3'd4
  } mode_e;

  typedef struct packed {
    logic [RAILS-1:0] sw;
    logic [RAILS-1:0] dis;
  } rail_plan_t;

  // A card is seen when at least one detect line is pulled low.
  function automatic logic card_seen(input logic a_n, input logic b_n);
    return ~(a_n & b_n);
  endfunction

  // Mode outside shutdown, derived from history and current inputs.
  function automatic mode_e next_base(input mode_e cur, input logic card,
                                      input logic rails_ok, input logic stby_n);
    mode_e nxt;
    if (!card) begin
      nxt = rails_ok ? M_NOCARD : M_OFF;
    end else begin
      case (cur)
        M_CARD, M_STBY: nxt = (rails_ok && stby_n) ? M_CARD : M_STBY;
        default:        nxt = (rails_ok && stby_n) ? M_CARD : M_OFF;
      endcase
    end
    return nxt;
  endfunction

  // Desired switch and pulldown pattern for each mode.
  function automatic rail_plan_t rail_plan(input mode_e m);
    rail_plan_t p;
    p.sw  = '0;
    p.dis = '0;
    case (m)
      M_SHDN, M_NOCARD: p.dis = '1;
      M_STBY:           p.sw[R_AUX] = 1'b1;
      M_CARD:           p.sw = '1;
      default: ;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/spc_mode_fsm.sv
module spc_mode_fsm
  import spc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  aux_ok,
  input  logic  v33_ok,
  input  logic  v15_ok,
  input  logic  det_a_n,
  input  logic  det_b_n,
  input  logic  shdn_n,
  input  logic  stby_n,
  output mode_e mode_q
);
  mode_e base_q;
  mode_e base_d;
  mode_e mode_d;

  logic card_present;
  logic rails_ok;
  logic shut_req;
  logic resume_ev;

  assign card_present = card_seen(det_a_n, det_b_n);
  assign rails_ok     = v33_ok & v15_ok;
  assign shut_req     = aux_ok & ~shdn_n;
  assign resume_ev    = (mode_q == M_SHDN) & aux_ok & shdn_n;

  always_comb begin
    base_d = base_q;
    mode_d = mode_q;
    if (!aux_ok) begin
      base_d = M_OFF;
      mode_d = M_OFF;
    end else if (shut_req) begin
      mode_d = M_SHDN;
    end else begin
      base_d = next_base(base_q, card_present, rails_ok, stby_n);
      mode_d = base_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= M_OFF;
      mode_q <= M_OFF;
    end else begin
      base_q <= base_d;
      mode_q <= mode_d;
    end
  end

  // R2
  aux_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !aux_ok |=> (mode_q == M_OFF));
  // R3
  shdn_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shut_req |=> (mode_q == M_SHDN));
  // R4
  shdn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shut_req |=> $stable(base_q));
  // R4
  resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_ev && card_present && rails_ok && stby_n && $past(base_q) == M_CARD
     && base_q == M_CARD) |=> (mode_q == M_CARD));
  // R5
  nocard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_ok && shdn_n && rails_ok && !card_present) |=> (mode_q == M_NOCARD));
endmodule

// File: rtl/spc_rail_bbm.sv
module spc_rail_bbm (
  input  logic clk,
  input  logic rst_n,
  input  logic want_sw,
  input  logic want_dis,
  output logic sw_o,
  output logic dis_o
);
  logic sw_q, dis_q;
  logic sw_d, dis_d;

  always_comb begin
    if (sw_q) begin
      sw_d  = want_sw;
      dis_d = 1'b0;
    end else if (dis_q) begin
      sw_d  = 1'b0;
      dis_d = want_dis;
    end else begin
      sw_d  = want_sw;
      dis_d = want_dis & ~want_sw;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q  <= 1'b0;
      dis_q <= 1'b0;
    end else begin
      sw_q  <= sw_d;
      dis_q <= dis_d;
    end
  end

  assign sw_o  = sw_q;
  assign dis_o = dis_q;

  // R9
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw_q && dis_q));
  // R9
  sw_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_q) |-> !$past(dis_q));
  // R9
  dis_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dis_q) |-> !$past(sw_q));
endmodule

// File: rtl/spc_rail_bank.sv
module spc_rail_bank
  import spc_pkg::*;
#(
  parameter int N = RAILS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] want_sw,
  input  logic [N-1:0] want_dis,
  output logic [N-1:0] sw_en,
  output logic [N-1:0] dis_en
);
  for (genvar i = 0; i < N; i++) begin : g_rail
    spc_rail_bbm u_bbm (
      .clk      (clk),
      .rst_n    (rst_n),
      .want_sw  (want_sw[i]),
      .want_dis (want_dis[i]),
      .sw_o     (sw_en[i]),
      .dis_o    (dis_en[i])
    );
  end
endmodule

// File: rtl/slot_power_ctrl.sv
module slot_power_ctrl
  import spc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                aux_ok,
  input  logic                v33_ok,
  input  logic                v15_ok,
  input  logic                det_pcie_n,
  input  logic                det_usb_n,
  input  logic                shdn_req_n,
  input  logic                stby_req_n,
  output logic [RAILS-1:0]    rail_sw_en,
  output logic [RAILS-1:0]    rail_dis_en,
  output logic [MODE_W-1:0]   mode_code
);
  mode_e      cur_mode;
  rail_plan_t plan;

  spc_mode_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .aux_ok  (aux_ok),
    .v33_ok  (v33_ok),
    .v15_ok  (v15_ok),
    .det_a_n (det_pcie_n),
    .det_b_n (det_usb_n),
    .shdn_n  (shdn_req_n),
    .stby_n  (stby_req_n),
    .mode_q  (cur_mode)
  );

  assign plan = rail_plan(cur_mode);

  spc_rail_bank #(.N(RAILS)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .want_sw  (plan.sw),
    .want_dis (plan.dis),
    .sw_en    (rail_sw_en),
    .dis_en   (rail_dis_en)
  );

  assign mode_code = cur_mode;

  // R10
  card_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == M_CARD && $past(cur_mode) == M_CARD && $past(cur_mode, 2) == M_CARD)
    |-> (rail_sw_en == '1 && rail_dis_en == '0));
  // R7
  stby_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == M_STBY && $past(cur_mode) == M_STBY && $past(cur_mode, 2) == M_STBY)
    |-> (rail_sw_en == 3'b001 && rail_dis_en == '0));
endmodule

// File: tb/slot_power_ctrl_tb.sv
module slot_power_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       aux_ok = 1'b0, v33_ok = 1'b0, v15_ok = 1'b0;
  logic       det_pcie_n = 1'b1, det_usb_n = 1'b1;
  logic       shdn_req_n = 1'b1, stby_req_n = 1'b1;
  logic [2:0] rail_sw_en, rail_dis_en, mode_code;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  slot_power_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .aux_ok(aux_ok), .v33_ok(v33_ok), .v15_ok(v15_ok),
    .det_pcie_n(det_pcie_n), .det_usb_n(det_usb_n),
    .shdn_req_n(shdn_req_n), .stby_req_n(stby_req_n),
    .rail_sw_en(rail_sw_en), .rail_dis_en(rail_dis_en), .mode_code(mode_code)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect3(input string req, input logic [2:0] m,
                         input logic [2:0] sw, input logic [2:0] dis);
    checks++;
    if (mode_code !== m || rail_sw_en !== sw || rail_dis_en !== dis) begin
      failures++;
      $display("FAIL %s: mode/sw/dis got %0d/%b/%b expected %0d/%b/%b",
               req, mode_code, rail_sw_en, rail_dis_en, m, sw, dis);
    end
  endtask

  task automatic go_nocard();
    aux_ok = 1; v33_ok = 1; v15_ok = 1;
    det_pcie_n = 1; det_usb_n = 1; shdn_req_n = 1; stby_req_n = 1;
    tick(4);
    expect3("R5", 3'd2, 3'b000, 3'b111);
  endtask

  task automatic t_reset();
    rst_n = 0;
    tick(2);
    expect3("R1 in reset", 3'd0, 3'b000, 3'b000);
    rst_n = 1;
    tick(1);
    expect3("R1 after release", 3'd0, 3'b000, 3'b000);
  endtask

  task automatic t_insert_timing();
    go_nocard();
    det_usb_n = 0;
    tick(1);
    expect3("R10 mode first", 3'd4, 3'b000, 3'b111);
    tick(1);
    expect3("R9 dead cycle", 3'd4, 3'b000, 3'b000);
    tick(1);
    expect3("R6 inserted via second line", 3'd4, 3'b111, 3'b000);
  endtask

  task automatic t_remove();
    det_usb_n = 1; det_pcie_n = 1;
    tick(1);
    expect3("R10 removal mode", 3'd2, 3'b111, 3'b000);
    tick(1);
    expect3("R9 switch off dead", 3'd2, 3'b000, 3'b000);
    tick(1);
    expect3("R5 after removal", 3'd2, 3'b000, 3'b111);
  endtask

  task automatic t_shutdown_from_card();
    go_nocard();
    det_pcie_n = 0;
    tick(4);
    expect3("R6 inserted via first line", 3'd4, 3'b111, 3'b000);
    shdn_req_n = 0;
    tick(3);
    expect3("R3 shutdown", 3'd1, 3'b000, 3'b111);
    shdn_req_n = 1;
    tick(1);
    expect3("R4 restore mode", 3'd4, 3'b000, 3'b111);
    tick(3);
    expect3("R4 restore rails", 3'd4, 3'b111, 3'b000);
  endtask

  task automatic t_standby_and_shutdown();
    stby_req_n = 0;
    tick(1);
    expect3("R7 standby mode", 3'd3, 3'b111, 3'b000);
    tick(1);
    expect3("R7 standby rails", 3'd3, 3'b001, 3'b000);
    shdn_req_n = 0;
    tick(4);
    expect3("R3 shutdown from standby", 3'd1, 3'b000, 3'b111);
    shdn_req_n = 1;
    tick(4);
    expect3("R4 standby restored", 3'd3, 3'b001, 3'b000);
    stby_req_n = 1;
    tick(4);
    expect3("R7 standby released", 3'd4, 3'b111, 3'b000);
  endtask

  task automatic t_supply_loss();
    v15_ok = 0;
    tick(3);
    expect3("R7 1.5V loss", 3'd3, 3'b001, 3'b000);
    v15_ok = 1;
    tick(3);
    expect3("R7 1.5V back", 3'd4, 3'b111, 3'b000);
    v33_ok = 0;
    tick(3);
    expect3("R7 3.3V loss", 3'd3, 3'b001, 3'b000);
    v33_ok = 1;
    tick(3);
  endtask

  task automatic t_stby_before_card();
    go_nocard();
    stby_req_n = 0;
    tick(2);
    expect3("R5 standby without card", 3'd2, 3'b000, 3'b111);
    det_pcie_n = 0;
    tick(4);
    expect3("R8 standby before card", 3'd0, 3'b000, 3'b000);
    stby_req_n = 1;
    tick(4);
    expect3("R8 standby cleared", 3'd4, 3'b111, 3'b000);
  endtask

  task automatic t_late_supply();
    go_nocard();
    v33_ok = 0;
    tick(3);
    expect3("R8 aux only no card", 3'd0, 3'b000, 3'b000);
    det_usb_n = 0;
    tick(3);
    expect3("R8 inserted without 3.3V", 3'd0, 3'b000, 3'b000);
    v33_ok = 1;
    tick(3);
    expect3("R8 late supply", 3'd4, 3'b111, 3'b000);
  endtask

  task automatic t_aux_loss();
    aux_ok = 0;
    tick(1);
    expect3("R2 aux loss mode", 3'd0, 3'b111, 3'b000);
    tick(2);
    expect3("R2 aux loss rails", 3'd0, 3'b000, 3'b000);
    shdn_req_n = 0;
    tick(3);
    expect3("R2 shutdown without aux", 3'd0, 3'b000, 3'b000);
    shdn_req_n = 1;
  endtask

  initial begin
    tick(1);
    t_reset();
    t_insert_timing();
    t_remove();
    t_shutdown_from_card();
    t_standby_and_shutdown();
    t_supply_loss();
    t_stby_before_card();
    t_late_supply();
    t_aux_loss();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule